// File: doc/BRIEF.md
# External Interrupt Controller with Per-Line Sense Selection

This block collects a parameterised number of asynchronous external interrupt lines (1 to 32) and folds them into a single combined interrupt request. Each line passes through a two-flop synchroniser. Its trigger sense is chosen by software: edge or level, and for each of these the polarity. Events are recorded in a pending vector. The pending vector is combined with a mask to form the interrupt output.

Software reaches the block through a simple 32-bit register bus. Writes take effect on the clock edge, and reads are combinational from the address. The mask has write-one-to-set and write-one-to-clear ports and a read-only view. Edge-latched pending bits are cleared with a write-one acknowledge. A one-bit control steers line 0 to a separate non-maskable output. Bits for lines that are not implemented cannot be written and read as zero. Software can therefore find the line count by writing all ones to the sense-mode register and counting the ones it reads back. The reset input is asynchronous and active low. It is assumed to be released synchronously to `clk` upstream.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, every register (mask, sense mode, edge polarity, level polarity, pending, non-maskable control) reads 0, and `irq_out` and `nmi_out` are low. Every line is therefore edge-sensitive on the falling edge and masked.
- R2: A write to byte offset 0x00 sets each mask bit whose data bit is 1. A write to 0x04 clears each mask bit whose data bit is 1. Zero data bits leave the mask unchanged. The mask is read at 0x08, and writes to 0x08 have no effect.
- R3: A line whose sense-mode bit (offset 0x14) is 0 is edge-sensitive. Its edge-polarity bit (offset 0x18) selects the rising edge when 1 and the falling edge when 0. The matching edge sets the line's pending bit, which stays set after the input returns, until it is acknowledged.
- R4: A line whose sense-mode bit is 1 is level-sensitive. Its level-polarity bit (offset 0x1C) selects active-high when 1 and active-low when 0. The pending bit follows the active level, and an acknowledge does not clear it while the level is still asserted.
- R5: Writing 1 to a bit at offset 0x10 clears that edge line's pending bit, and zero bits have no effect. If an edge event arrives in the same cycle as the acknowledge, the event wins and the bit stays set.
- R6: For lines at or above NUM_LINES, the bits of every per-line register read 0 and cannot be written. Writing all ones to offset 0x14 reads back exactly NUM_LINES ones in the low bits.
- R7: The pending vector reads at offset 0x0C regardless of the mask. `irq_out` is high exactly when some line has both its pending bit and its mask bit set. While non-maskable steering is on, line 0 is left out of this.
- R8: Bit 0 of offset 0x24 enables non-maskable steering, and the other bits of that register read 0. While steering is on, `nmi_out` equals line 0's pending bit whatever its mask bit, and line 0 does not raise `irq_out`. While steering is off, `nmi_out` is low.
- R9: A change on an input pin is visible in the pending bit after the third rising clock edge that follows it, and not after the first two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_LINES | Asynchronous external interrupt lines |
| bus_addr | input | 6 | Byte address of the register |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_out | output | 1 | Combined maskable interrupt request |
| nmi_out | output | 1 | Non-maskable interrupt request from line 0 |

## Verification
The bench checks the exact synchroniser latency by sampling the pending bit after each of the first three edges. A design with one stage too few or too many would show the bit one cycle early or late. It puts an acknowledge in the same cycle as a fresh edge event. A design that gives the clear priority would drop that event for good. It acknowledges a level line whose input is still active, where a wrong design would leave the bit clear. It probes the line count with an all-ones write, where a design that stores unimplemented bits would report 32 lines. It also sets line 0's mask bit while steering is on, to catch a design that asserts both outputs or gates the non-maskable path with the mask.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 6;

  // Byte offsets: software depends on these positions.
  localparam logic [ADDR_W-1:0] OFS_EN_SET = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_EN_CLR = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_PEND   = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_ACK    = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_SENSE  = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_EDGPOL = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_LVLPOL = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_NMI    = 6'h24;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] cur_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [WIDTH-1:0] meta_q, sync_q, hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      hist_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  assign cur_o  = sync_q;
  assign prev_o = hist_q;
endmodule

// File: rtl/irq_line_sense.sv
module irq_line_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,      // 1 = level, 0 = edge
  input  logic edge_pol_i,  // 1 = rising, 0 = falling
  input  logic lvl_pol_i,   // 1 = high, 0 = low
  input  logic cur_i,
  input  logic prev_i,
  input  logic ack_i,
  output logic pend_o
);
  logic pend_q, pend_d;
  logic rise, fall, edge_hit, lvl_hit;

  always_comb begin
    rise     = cur_i & ~prev_i;
    fall     = ~cur_i & prev_i;
    edge_hit = edge_pol_i ? rise : fall;
    lvl_hit  = (cur_i == lvl_pol_i);
    if (mode_i) pend_d = lvl_hit;
    else        pend_d = edge_hit | (pend_q & ~ack_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && pend_q && !ack_i) |=> pend_q); // R3
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && ack_i && (cur_i == prev_i)) |=> !pend_q); // R5
  AST_LVL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && (cur_i != lvl_pol_i)) |=> !pend_q); // R4
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import eic_pkg::*;
#(
  parameter int NUM_LINES = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wen_i,
  input  logic [REG_W-1:0]     wdata_i,
  input  logic [NUM_LINES-1:0] pend_i,
  output logic [NUM_LINES-1:0] mask_o,
  output logic [NUM_LINES-1:0] mode_o,
  output logic [NUM_LINES-1:0] edge_o,
  output logic [NUM_LINES-1:0] lvl_o,
  output logic [NUM_LINES-1:0] ack_o,
  output logic                 nmi_en_o,
  output logic [REG_W-1:0]     rdata_o
);
  logic [NUM_LINES-1:0] mask_q, mask_d, mode_q, mode_d;
  logic [NUM_LINES-1:0] edge_q, edge_d, lvl_q, lvl_d;
  logic                 nmi_q, nmi_d;
  logic                 mask_en, mode_en, edge_en, lvl_en, nmi_en;
  logic [NUM_LINES-1:0] wd;
  logic                 unused_wdata;

  assign wd           = wdata_i[NUM_LINES-1:0];
  assign unused_wdata = ^wdata_i;

  function automatic logic [REG_W-1:0] widen(input logic [NUM_LINES-1:0] v);
    widen = '0;
    widen[NUM_LINES-1:0] = v;
  endfunction

  // Clock enables
  always_comb begin
    mask_en = wen_i && ((addr_i == OFS_EN_SET) || (addr_i == OFS_EN_CLR));
    mode_en = wen_i && (addr_i == OFS_SENSE);
    edge_en = wen_i && (addr_i == OFS_EDGPOL);
    lvl_en  = wen_i && (addr_i == OFS_LVLPOL);
    nmi_en  = wen_i && (addr_i == OFS_NMI);
  end

  // Next state
  always_comb begin
    mask_d = (addr_i == OFS_EN_SET) ? (mask_q | wd) : (mask_q & ~wd);
    mode_d = wd;
    edge_d = wd;
    lvl_d  = wd;
    nmi_d  = wdata_i[0];
    ack_o  = (wen_i && (addr_i == OFS_ACK)) ? wd : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      mode_q <= '0;
      edge_q <= '0;
      lvl_q  <= '0;
      nmi_q  <= 1'b0;
    end else begin
      if (mask_en) mask_q <= mask_d;
      if (mode_en) mode_q <= mode_d;
      if (edge_en) edge_q <= edge_d;
      if (lvl_en)  lvl_q  <= lvl_d;
      if (nmi_en)  nmi_q  <= nmi_d;
    end
  end

  // Readback
  always_comb begin
    case (addr_i)
      OFS_MASK:   rdata_o = widen(mask_q);
      OFS_PEND:   rdata_o = widen(pend_i);
      OFS_SENSE:  rdata_o = widen(mode_q);
      OFS_EDGPOL: rdata_o = widen(edge_q);
      OFS_LVLPOL: rdata_o = widen(lvl_q);
      OFS_NMI:    rdata_o = {{(REG_W-1){1'b0}}, nmi_q};
      default:    rdata_o = '0;
    endcase
  end

  assign mask_o   = mask_q;
  assign mode_o   = mode_q;
  assign edge_o   = edge_q;
  assign lvl_o    = lvl_q;
  assign nmi_en_o = nmi_q;

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wen_i && addr_i == OFS_EN_SET) |=> ((mask_q & $past(wd)) == $past(wd))); // R2
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wen_i && addr_i == OFS_EN_CLR) |=> ((mask_q & $past(wd)) == '0)); // R2
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wen_i && (addr_i == OFS_EN_SET || addr_i == OFS_EN_CLR)) |=> $stable(mask_q)); // R2
  AST_NMI_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == OFS_NMI) |-> (rdata_o[REG_W-1:1] == '0)); // R8
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eic_pkg::*;
#(
  parameter int NUM_LINES = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wen,
  input  logic [REG_W-1:0]     bus_wdata,
  output logic [REG_W-1:0]     bus_rdata,
  output logic                 irq_out,
  output logic                 nmi_out
);
  logic [NUM_LINES-1:0] cur, prev, pend, mask, mode, edg, lvl, ack, gated;
  logic                 nmi_en;

  irq_sync #(.WIDTH(NUM_LINES)) sync_i (
    .clk(clk), .rst_n(rst_n), .async_i(irq_in), .cur_o(cur), .prev_o(prev)
  );

  irq_regs #(.NUM_LINES(NUM_LINES)) regs_i (
    .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .wen_i(bus_wen),
    .wdata_i(bus_wdata), .pend_i(pend), .mask_o(mask), .mode_o(mode),
    .edge_o(edg), .lvl_o(lvl), .ack_o(ack), .nmi_en_o(nmi_en),
    .rdata_o(bus_rdata)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    irq_line_sense line_i (
      .clk(clk), .rst_n(rst_n), .mode_i(mode[i]), .edge_pol_i(edg[i]),
      .lvl_pol_i(lvl[i]), .cur_i(cur[i]), .prev_i(prev[i]), .ack_i(ack[i]),
      .pend_o(pend[i])
    );
  end

  always_comb begin
    gated    = pend & mask;
    gated[0] = gated[0] & ~nmi_en;
    irq_out  = |gated;
    nmi_out  = nmi_en & pend[0];
  end

  AST_IRQ_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    (!nmi_en && ((pend & mask) != '0)) |-> irq_out); // R7
  AST_IRQ_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & mask) == '0) |-> !irq_out); // R7
  AST_NMI_STEER: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_en && pend[0]) |-> nmi_out); // R8
  AST_NMI_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !nmi_en |-> !nmi_out); // R8
endmodule

// File: tb/ext_irq_ctrl_tb_top.sv
`timescale 1ns/100ps
module ext_irq_ctrl_tb_top;
  localparam int N = 12;
  localparam logic [5:0] A_SET = 6'h00, A_CLR = 6'h04, A_MASK = 6'h08,
    A_PEND = 6'h0C, A_ACK = 6'h10, A_SENSE = 6'h14, A_EDG = 6'h18,
    A_LVL = 6'h1C, A_NMI = 6'h24;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] irq_in;
  logic [5:0]   bus_addr;
  logic         bus_wen;
  logic [31:0]  bus_wdata, bus_rdata;
  logic         irq_out, nmi_out;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  ext_irq_ctrl #(.NUM_LINES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_wen(bus_wen), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .nmi_out(nmi_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(posedge clk);
    #1 bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  function automatic logic [N-1:0] model_pend(input logic [N-1:0] mode, input logic [N-1:0] edg,
      input logic [N-1:0] lvl, input logic [N-1:0] oldv, input logic [N-1:0] newv);
    for (int i = 0; i < N; i++) begin
      if (mode[i]) model_pend[i] = (newv[i] == lvl[i]);
      else if (edg[i]) model_pend[i] = !oldv[i] && newv[i];
      else model_pend[i] = oldv[i] && !newv[i];
    end
  endfunction

  function automatic logic [31:0] ext(input logic [N-1:0] v);
    ext = '0;
    ext[N-1:0] = v;
  endfunction

  initial begin : watchdog
    wait_cyc(150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    logic [31:0] seed;
    logic [N-1:0] all1;
    all1 = '1;
    seed = $urandom(32'h00C0FFEE);
    rst_n = 1'b0; irq_in = '0; bus_addr = '0; bus_wen = 1'b0; bus_wdata = '0;
    wait_cyc(3);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(A_MASK, d);  check("R1 mask", d, 0);
    rd(A_PEND, d);  check("R1 pend", d, 0);
    rd(A_SENSE, d); check("R1 mode", d, 0);
    rd(A_EDG, d);   check("R1 edge", d, 0);
    rd(A_LVL, d);   check("R1 level", d, 0);
    rd(A_NMI, d);   check("R1 nmi", d, 0);
    check("R1 irq_out", {31'd0, irq_out}, 0);
    check("R1 nmi_out", {31'd0, nmi_out}, 0);

    // R2 mask set/clear
    wr(A_SET, 32'h5);  rd(A_MASK, d); check("R2 set", d, 32'h5);
    wr(A_SET, 32'h2);  rd(A_MASK, d); check("R2 set keeps", d, 32'h7);
    wr(A_CLR, 32'h4);  rd(A_MASK, d); check("R2 clr", d, 32'h3);
    wr(A_SET, 32'h0);  rd(A_MASK, d); check("R2 zero set", d, 32'h3);
    wr(A_CLR, 32'h0);  rd(A_MASK, d); check("R2 zero clr", d, 32'h3);
    wr(A_MASK, 32'hFFFF_FFFF); rd(A_MASK, d); check("R2 mask ro", d, 32'h3);
    wr(A_CLR, 32'hFFFF_FFFF);  rd(A_MASK, d); check("R2 clr all", d, 0);

    // R6 line count probe
    wr(A_SENSE, 32'hFFFF_FFFF); rd(A_SENSE, d);
    check("R6 probe", d, ext(all1));
    check("R6 count", $countones(d), N);
    wr(A_EDG, 32'hFFFF_FFFF); rd(A_EDG, d); check("R6 edge upper", d, ext(all1));
    wr(A_LVL, 32'hFFFF_FFFF); rd(A_LVL, d); check("R6 level upper", d, ext(all1));
    wr(A_SET, 32'hFFFF_FFFF); rd(A_MASK, d); check("R6 mask upper", d, ext(all1));
    wr(A_SENSE, 0); wr(A_EDG, 0); wr(A_LVL, 0); wr(A_CLR, 32'hFFFF_FFFF);
    wr(A_ACK, 32'hFFFF_FFFF);

    // R8 control readback
    wr(A_NMI, 32'hFFFF_FFFF); rd(A_NMI, d); check("R8 nmi bits", d, 1);
    wr(A_NMI, 0);             rd(A_NMI, d); check("R8 nmi off", d, 0);

    // R9 latency and R3 rising edge on line 3
    wr(A_EDG, 32'h8);
    @(negedge clk); irq_in[3] = 1'b1; bus_addr = A_PEND;
    @(posedge clk); #1 check("R9 edge1", bus_rdata, 0);
    @(posedge clk); #1 check("R9 edge2", bus_rdata, 0);
    @(posedge clk); #1 check("R9 edge3", bus_rdata, 32'h8);
    @(negedge clk); irq_in[3] = 1'b0;
    wait_cyc(5);
    rd(A_PEND, d); check("R3 latched", d, 32'h8);
    check("R7 masked no irq", {31'd0, irq_out}, 0);
    wr(A_SET, 32'h8); #1 check("R7 irq on", {31'd0, irq_out}, 1);
    wr(A_ACK, 32'h0); rd(A_PEND, d); check("R5 zero ack", d, 32'h8);
    wr(A_ACK, 32'h8); rd(A_PEND, d); check("R5 ack", d, 0);
    check("R7 irq off", {31'd0, irq_out}, 0);
    wr(A_CLR, 32'h8);

    // R3 falling edge (default) on line 2
    @(negedge clk); irq_in[2] = 1'b1;
    wait_cyc(5); rd(A_PEND, d); check("R3 no rise event", d, 0);
    @(negedge clk); irq_in[2] = 1'b0;
    wait_cyc(5); rd(A_PEND, d); check("R3 fall event", d, 32'h4);
    wr(A_ACK, 32'h4);

    // R5 event and ack in the same cycle
    @(negedge clk); irq_in[3] = 1'b1;
    @(posedge clk); @(posedge clk);
    wr(A_ACK, 32'h8);
    rd(A_PEND, d); check("R5 event beats ack", d, 32'h8);
    wr(A_ACK, 32'h8); rd(A_PEND, d); check("R5 ack after", d, 0);
    @(negedge clk); irq_in[3] = 1'b0;
    wait_cyc(5);

    // R4 level high on line 4, level low on line 5
    wr(A_LVL, 32'h10); wr(A_SENSE, 32'h30);
    wait_cyc(2);
    rd(A_PEND, d); check("R4 active-low idle pending", d, 32'h20);
    @(negedge clk); irq_in[4] = 1'b1; irq_in[5] = 1'b1;
    wait_cyc(5); rd(A_PEND, d); check("R4 high active", d, 32'h10);
    wr(A_ACK, 32'h30); wait_cyc(2);
    rd(A_PEND, d); check("R4 ack no lasting effect", d, 32'h10);
    @(negedge clk); irq_in[4] = 1'b0;
    wait_cyc(5); rd(A_PEND, d); check("R4 follows drop", d, 0);
    @(negedge clk); irq_in[5] = 1'b0;
    wr(A_SENSE, 0); wr(A_LVL, 0); wr(A_ACK, 32'hFFFF_FFFF);

    // R8 line 0 steering
    wr(A_EDG, 32'h1); wr(A_NMI, 1); wr(A_SET, 32'h1);
    @(negedge clk); irq_in[0] = 1'b1;
    wait_cyc(5); #1;
    check("R8 nmi_out", {31'd0, nmi_out}, 1);
    check("R8 irq quiet", {31'd0, irq_out}, 0);
    wr(A_CLR, 32'h1); #1 check("R8 nmi unmasked", {31'd0, nmi_out}, 1);
    wr(A_SET, 32'h1); wr(A_NMI, 0); #1;
    check("R8 steering off nmi", {31'd0, nmi_out}, 0);
    check("R7 line0 back on irq", {31'd0, irq_out}, 1);
    wr(A_ACK, 32'h1); wr(A_CLR, 32'hFFFF_FFFF); wr(A_EDG, 0);

    // Random configurations (R3 R4 R5 R7 R8)
    for (int it = 0; it < 60; it++) begin
      logic [N-1:0] mode, edg, lvl, msk, oldv, newv, exp;
      logic nmi;
      logic e_irq, e_nmi;
      oldv = irq_in;
      mode = N'($urandom); edg = N'($urandom); lvl = N'($urandom);
      msk = N'($urandom); nmi = 1'($urandom);
      newv = N'($urandom);
      wr(A_SENSE, ext(mode)); wr(A_EDG, ext(edg)); wr(A_LVL, ext(lvl));
      wr(A_CLR, 32'hFFFF_FFFF); wr(A_SET, ext(msk)); wr(A_NMI, {31'd0, nmi});
      wr(A_ACK, 32'hFFFF_FFFF);
      wait_cyc(1);
      rd(A_PEND, d);
      check("R4 R5 random after ack", d, ext(model_pend(mode, edg, lvl, oldv, oldv)));
      @(negedge clk); irq_in = newv;
      wait_cyc(5);
      exp = model_pend(mode, edg, lvl, oldv, newv);
      rd(A_PEND, d);
      check("R3 R4 random pend", d, ext(exp));
      e_nmi = nmi && exp[0];
      exp = exp & msk;
      if (nmi) exp[0] = 1'b0;
      e_irq = |exp;
      check("R7 random irq", {31'd0, irq_out}, {31'd0, e_irq});
      check("R8 random nmi", {31'd0, nmi_out}, {31'd0, e_nmi});
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule